// File: doc/BRIEF.md
# Sampled Burst-Mode Controller

This block is a clocked model of an unclocked Mealy-style controller whose behaviour is set by a fixed table of specification states. Three single-bit control inputs are synchronised and then compared each cycle against the values they held when the current specification state was entered. Each state lists one or two input bursts. A burst is an unordered set of input edges, and each burst is paired with an output burst and a successor state. Edges of a burst may arrive in any order and with any spacing. Once every edge of a burst is present, the two outputs flip as that burst specifies and the engine moves to the successor state in the same register update.

Any input activity that the current state does not allow raises a one-cycle-per-occurrence fault flag. This covers an edge that no burst lists, an edge that returns toward its entry value before the burst completes, and any change during the single settling cycle that follows each completion. A state may mark an input as a free-running don't-care that is neither counted nor flagged. The block is used as a protocol checker and sequencer, and it replaces a hand-drawn asynchronous controller in a synchronous design flow.

Top module: `burst_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the outputs are out_yz = 2'b01 (bit1 = Y, bit0 = Z), fault is 0, the state is HOME and the captured entry inputs are 3'b000 (bit2 = A, bit1 = B, bit0 = C).
- R2: When every edge of a listed burst is present, out_yz toggles the bits of that burst's output mask and the state advances in the same update. This happens 3 clock edges after the completing input is applied: 2 synchroniser stages plus the engine register. The table is: HOME {A+,C+} flips Z and goes to LEFT; HOME {A+,B+} flips Y and Z and goes to RIGHT; LEFT {C-} flips Y and goes to JOIN; RIGHT {B-} flips nothing and goes to JOIN; JOIN {A-} flips Y and Z and goes to HOME.
- R3: Edges of a burst are accepted in any order, separately or together, with any spacing. A partially arrived burst changes neither out_yz nor fault.
- R4: A burst whose output mask is empty (RIGHT {B-}) still advances the state and leaves out_yz unchanged.
- R5: In HOME the two bursts lead to different outputs, and at most one burst ever matches: {A+,C+} gives out_yz = 2'b00 and {A+,B+} gives out_yz = 2'b10.
- R6: An input change that is not part of any burst of the current state and is not a don't-care sets fault 3 edges after it is applied. The state and outputs stay unchanged.
- R7: An input that returns to its entry value before its burst completes sets fault for one cycle.
- R8: In LEFT, input B is a don't-care. Toggling it sets no fault, completes nothing and leaves out_yz unchanged.
- R9: The cycle after a completion is a settling cycle. Any input change seen by the engine in that cycle sets fault, and state and outputs hold through it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 3 | Asynchronous control inputs: bit2 A, bit1 B, bit0 C |
| out_yz | output | 2 | Controller outputs: bit1 Y, bit0 Z |
| fault | output | 1 | High for each cycle an illegal input condition is seen |

## Verification
Every result appears 3 rising edges after its input changes: two synchroniser flops and then the engine register. The bench therefore drives inputs on a falling edge and samples three falling edges later. The settling-cycle check applies the completing edge and then, one cycle later, a second change. That change reaches the engine exactly in the settling cycle, so fault is sampled 4 falling edges after the first drive. The retreat fault lasts a single cycle, and it is sampled on the exact falling edge after the engine sees the return.

// File: rtl/burst_ctl_pkg.sv
// Package: sizes, types and the fixed specification table for burst_ctl.
// Assumes the table obeys the maximal-set and unique-entry rules.
package burst_ctl_pkg;
    localparam int NIN  = 3;            // control inputs A,B,C (bit2..bit0)
    localparam int NOUT = 2;            // outputs Y,Z (bit1..bit0)
    localparam int NST  = 4;            // specification states
    localparam int NARC = 2;            // bursts per state, max
    localparam int SW   = $clog2(NST);

    typedef logic [NIN-1:0]  ivec_t;
    typedef logic [NOUT-1:0] ovec_t;
    typedef logic [SW-1:0]   st_t;

    localparam st_t   ST_HOME  = 2'd0;
    localparam st_t   ST_LEFT  = 2'd1;
    localparam st_t   ST_RIGHT = 2'd2;
    localparam st_t   ST_JOIN  = 2'd3;
    localparam ivec_t IN_RST   = 3'b000;
    localparam ovec_t OUT_RST  = 2'b01;

    typedef struct packed {
        logic  vld;   // burst exists
        ivec_t trig;  // inputs that must all differ from entry values
        ovec_t flip;  // outputs toggled on completion
        st_t   nxt;   // successor state
    } arc_t;

    // Build one table entry.
    function automatic arc_t mk(input ivec_t t, input ovec_t f, input st_t n);
        arc_t a;
        a.vld  = 1'b1;
        a.trig = t;
        a.flip = f;
        a.nxt  = n;
        return a;
    endfunction

    // Table lookup: burst k of state st.
    function automatic arc_t arc_of(input st_t st, input int k);
        arc_t a;
        a = '0;
        case (st)
            ST_HOME:  a = (k == 0) ? mk(3'b101, 2'b01, ST_LEFT) : mk(3'b110, 2'b11, ST_RIGHT);
            ST_LEFT:  if (k == 0) a = mk(3'b001, 2'b10, ST_JOIN);
            ST_RIGHT: if (k == 0) a = mk(3'b010, 2'b00, ST_JOIN);
            default:  if (k == 0) a = mk(3'b100, 2'b11, ST_HOME);
        endcase
        return a;
    endfunction

    // Directed don't-care inputs of a state.
    function automatic ivec_t dc_of(input st_t st);
        return (st == ST_LEFT) ? 3'b010 : 3'b000;
    endfunction
endpackage

// File: rtl/burst_sync.sv
// Module: multi-stage synchroniser for the asynchronous control inputs.
// Assumes each bit is independent; stage count is a parameter (>=1).
module burst_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift the input one stage deeper per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/burst_match.sv
// Module: per-burst completion and coverage decode for the current state.
// Assumes diff is the change vector with don't-care bits already removed.
module burst_match
    import burst_ctl_pkg::*;
(
    input  st_t             st,
    input  ivec_t           eff,
    output logic [NARC-1:0] hit,
    output logic            legal
);
    logic [NARC-1:0] cov;

    for (genvar k = 0; k < NARC; k++) begin : g_arc
        // Completion: the changed set equals this burst exactly.
        assign hit[k] = arc_of(st, k).vld && (eff == arc_of(st, k).trig);
        // Coverage: the changed set is still inside this burst.
        assign cov[k] = arc_of(st, k).vld && ((eff & ~arc_of(st, k).trig) == '0);
    end

    assign legal = |cov;
endmodule

// File: rtl/burst_ctl.sv
// Module: top of the sampled burst-mode controller.
// Compares synchronised inputs to the entry snapshot, fires the matching
// output burst, flags illegal activity and holds one settling cycle.
// Assumes the table in burst_ctl_pkg is well formed.
module burst_ctl
    import burst_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  sig_in,
    output logic [1:0]  out_yz,
    output logic        fault
);
    ivec_t           smp, ent, pdiff, diff, dc, eff;
    st_t             st;
    logic            busy, legal, fire, retreat;
    logic [NARC-1:0] hit;
    arc_t            sel;

    burst_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sig_in), .q(smp)
    );

    assign diff = smp ^ ent;
    assign dc   = dc_of(st);
    assign eff  = diff & ~dc;

    burst_match u_match (.st(st), .eff(eff), .hit(hit), .legal(legal));

    assign fire    = (|hit) && !busy;
    assign retreat = |(pdiff & ~diff & ~dc);

    // Pick the completed burst's table entry.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NARC; k++)
            if (hit[k]) sel = arc_of(st, k);
    end

    // Engine register: settle, fire, or watch for illegal changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HOME;
            ent    <= IN_RST;
            pdiff  <= '0;
            busy   <= 1'b0;
            out_yz <= OUT_RST;
            fault  <= 1'b0;
        end else if (busy) begin
            busy  <= 1'b0;
            fault <= (smp != ent);
            pdiff <= diff;
        end else if (fire) begin
            out_yz <= out_yz ^ sel.flip;
            st     <= sel.nxt;
            ent    <= smp;
            busy   <= 1'b1;
            pdiff  <= '0;
            fault  <= 1'b0;
        end else begin
            fault <= !legal || retreat;
            pdiff <= diff;
        end
    end

    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    assert_out_with_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_yz) |-> !$stable(st));
    assert_state_then_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st) |-> busy);
    assert_settle_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_hold_in_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st) && $stable(out_yz)));
    assert_flag_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !legal) |=> fault);
endmodule

// File: tb/sim_burst_ctl.sv
module sim_burst_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sig_in = 3'b000;
    logic [1:0] out_yz;
    logic       fault;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    burst_ctl u0 (.clk(clk), .rst_n(rst_n), .sig_in(sig_in), .out_yz(out_yz), .fault(fault));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] v);
        @(negedge clk);
        sig_in = v;
    endtask

    task automatic settle3();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sig_in = 3'b000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk("R1 out_yz", {2'b0, out_yz}, 4'h1);
        chk("R1 fault", {3'b0, fault}, 4'h0);
    endtask

    // Full loop HOME->LEFT->JOIN->HOME, C edge first then A.
    task automatic t_loop_c_first();
        do_reset();
        put(3'b001); settle3();
        chk("R3 partial out", {2'b0, out_yz}, 4'h1);
        chk("R3 partial fault", {3'b0, fault}, 4'h0);
        put(3'b101); settle3();
        chk("R2 HOME AC out", {2'b0, out_yz}, 4'h0);
        chk("R2 HOME AC fault", {3'b0, fault}, 4'h0);
        put(3'b100); settle3();
        chk("R2 LEFT C- out", {2'b0, out_yz}, 4'h2);
        put(3'b000); settle3();
        chk("R2 JOIN A- out", {2'b0, out_yz}, 4'h1);
        chk("R2 loop fault", {3'b0, fault}, 4'h0);
    endtask

    task automatic t_order_a_first();
        do_reset();
        put(3'b100); repeat (6) @(negedge clk);
        chk("R3 A first partial", {2'b0, out_yz}, 4'h1);
        put(3'b101); settle3();
        chk("R3 A first done", {2'b0, out_yz}, 4'h0);
        chk("R3 A first fault", {3'b0, fault}, 4'h0);
    endtask

    task automatic t_order_together();
        do_reset();
        put(3'b101); settle3();
        chk("R3 together done", {2'b0, out_yz}, 4'h0);
    endtask

    // HOME {A+,B+} route, then empty output burst in RIGHT.
    task automatic t_right_route();
        do_reset();
        put(3'b010); settle3();
        put(3'b110); settle3();
        chk("R5 HOME AB out", {2'b0, out_yz}, 4'h2);
        put(3'b100); settle3();
        chk("R4 empty burst out", {2'b0, out_yz}, 4'h2);
        chk("R4 empty burst fault", {3'b0, fault}, 4'h0);
        put(3'b000); settle3();
        chk("R4 state moved to JOIN", {2'b0, out_yz}, 4'h1);
    endtask

    task automatic t_unexpected_r6();
        do_reset();
        put(3'b011); settle3();
        chk("R6 BC in HOME fault", {3'b0, fault}, 4'h1);
        chk("R6 BC in HOME out", {2'b0, out_yz}, 4'h1);
        do_reset();
        put(3'b101); settle3();
        put(3'b001); settle3();
        chk("R6 A- in LEFT fault", {3'b0, fault}, 4'h1);
        chk("R6 A- in LEFT out", {2'b0, out_yz}, 4'h0);
    endtask

    task automatic t_retreat_r7();
        do_reset();
        put(3'b100); settle3();
        chk("R7 before retreat", {3'b0, fault}, 4'h0);
        put(3'b000); settle3();
        chk("R7 retreat fault", {3'b0, fault}, 4'h1);
        @(negedge clk);
        chk("R7 retreat one cycle", {3'b0, fault}, 4'h0);
    endtask

    task automatic t_dontcare_r8();
        do_reset();
        put(3'b101); settle3();
        put(3'b111); settle3();
        chk("R8 B up fault", {3'b0, fault}, 4'h0);
        chk("R8 B up out", {2'b0, out_yz}, 4'h0);
        put(3'b101); settle3();
        chk("R8 B down fault", {3'b0, fault}, 4'h0);
        put(3'b100); settle3();
        chk("R8 LEFT still completes", {2'b0, out_yz}, 4'h2);
    endtask

    task automatic t_settle_r9();
        do_reset();
        put(3'b101);
        put(3'b100);
        settle3();
        chk("R9 settle fault", {3'b0, fault}, 4'h1);
        chk("R9 settle out", {2'b0, out_yz}, 4'h0);
    endtask

    initial begin
        t_reset_r1();
        t_loop_c_first();
        t_order_a_first();
        t_order_together();
        t_right_route();
        t_unexpected_r6();
        t_retreat_r7();
        t_dontcare_r8();
        t_settle_r9();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule